// File: doc/BRIEF.md
# Clause 22 Management Frame Master

This block runs single management transactions against an external Ethernet PHY over a two-wire serial management bus. The host presents one request at a time: a read or write flag, a 5-bit PHY address, a register address and 16-bit write data. The block builds the serial clock from the system clock through a parameterised divider. Every frame opens with a preamble of ones. The block shifts the command out MSB-first and handles the turnaround. It returns read data with a busy/done handshake.

Each serial bit has a low half and a high half of the management clock. Outgoing bits change only at the start of the low half. Incoming bits are captured at the end of the low half, just as the clock rises. The host register-address field is wider than the 5 bits the frame can carry. A request whose address does not fit is answered at once and never reaches the wire.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and whenever `busy` is low, `mdc` is low and `mdio_oe` is low; `done` is low after reset.
- R2: While a transaction runs, `mdc` toggles every `HALF_DIV` system clocks, so one serial bit lasts 2*`HALF_DIV` clocks (default 20, giving 2.5 MHz from 50 MHz).
- R3: Every accepted transaction starts with 33 serial bits driven as 1 with `mdio_oe` high.
- R4: A read then drives 14 bits MSB-first: `01`, `10`, the 5-bit PHY address, the 5-bit register address.
- R5: A read then releases `mdio_oe` for 19 clocks. The first 2 are turnaround, the next 16 form `rd_data` MSB-first, and the 19th is discarded. A read takes 66 `mdc` rising edges in total.
- R6: A write drives a 32-bit frame MSB-first after the preamble: `01`, `01`, PHY address, register address, `10`, 16 data bits.
- R7: After the write frame, `mdio_oe` is low for exactly 2 more `mdc` cycles before completion (67 rising edges in total).
- R8: `mdio_o` and `mdio_oe` change only where `mdc` goes or stays low. Input bits are taken from `mdio_i` at the rising edge of `mdc`.
- R9: A request whose register address has any bit at or above bit 5 set produces no `mdc` edge and no `busy`. `done` rises in the cycle after the request. A read of this kind returns `rd_data` = 0xFFFF, and a write leaves `rd_data` unchanged.
- R10: `busy` is high from the cycle after acceptance until completion. Requests presented while `busy` is high are ignored. `busy` falls in the same cycle `done` rises.
- R11: `done` is a single-cycle pulse per transaction. It is first seen 132*`HALF_DIV` clock edges after the accepting edge for a read, and 134*`HALF_DIV` for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 8 | Register address (only values below 32 are carried out) |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data of the last completed read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Reads are tried with response words 0x1234, 0xA5C3, 0x0000 and 0xFFFF. These expose bit-order and off-by-one sampling errors, and they also expose confusion between data bits and the turnaround or idle bits, which the bench drives as opposite values. Writes with the all-ones address and register check the complete 32-bit frame, the preamble count and the two released tail clocks. Out-of-range register addresses show the frame is never started. A request issued in the middle of a read shows that nothing is queued behind the running transaction.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_CMD,
        ST_RDIN,
        ST_TAIL
    } mst_state_e;

    localparam logic [1:0] FRM_START = 2'b01;
    localparam logic [1:0] FRM_OP_RD = 2'b10;
    localparam logic [1:0] FRM_OP_WR = 2'b01;
    localparam logic [1:0] FRM_TA_WR = 2'b10;

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int HALF_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic lo_end,
    output logic hi_end
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          phase;
    } div_t;

    div_t d, q;
    logic wrap;

    always_comb begin
        d    = q;
        wrap = (q.cnt == LAST);
        if (!run) begin
            d.cnt   = '0;
            d.phase = 1'b0;
        end else if (wrap) begin
            d.cnt   = '0;
            d.phase = ~q.phase;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc    = q.phase;
    assign lo_end = run && !q.phase && wrap;
    assign hi_end = run &&  q.phase && wrap;
endmodule

// File: rtl/mdio_frame_fmt.sv
module mdio_frame_fmt
    import mdio_pkg::*;
#(
    parameter int PHY_W  = 5,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16,
    localparam int FRM_W = 6 + PHY_W + REG_W + DATA_W
) (
    input  logic              is_write,
    input  logic [PHY_W-1:0]  phy,
    input  logic [REG_W-1:0]  regad,
    input  logic [DATA_W-1:0] wdata,
    output logic [FRM_W-1:0]  frame
);
    always_comb begin
        if (is_write)
            frame = {FRM_START, FRM_OP_WR, phy, regad, FRM_TA_WR, wdata};
        else
            frame = {FRM_START, FRM_OP_RD, phy, regad, {(DATA_W + 2){1'b0}}};
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 10,
    parameter int PHY_W    = 5,
    parameter int REG_W    = 5,
    parameter int REG_IN_W = 8,
    parameter int DATA_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [PHY_W-1:0]    req_phy,
    input  logic [REG_IN_W-1:0] req_reg,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-1:0]   rd_data,
    output logic                mdc,
    output logic                mdio_o,
    output logic                mdio_oe,
    input  logic                mdio_i
);
    localparam int PRE_BITS = 33;
    localparam int RD_CMD   = 4 + PHY_W + REG_W;
    localparam int WR_BITS  = RD_CMD + 2 + DATA_W;
    localparam int RD_IN    = DATA_W + 3;
    localparam int TAIL     = 2;
    localparam int CNT_W    = $clog2(PRE_BITS + WR_BITS);

    typedef struct packed {
        mst_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [WR_BITS-1:0] sh;
        logic [DATA_W-1:0]  din;
        logic               wr;
        logic               mo;
        logic               oe;
        logic               done;
        logic [DATA_W-1:0]  rdata;
    } mst_t;

    mst_t d, q;
    logic addr_bad;
    logic lo_end, hi_end, run;
    logic [WR_BITS-1:0] frame;

    generate
        if (REG_IN_W > REG_W) begin : g_range
            assign addr_bad = |req_reg[REG_IN_W-1:REG_W];
        end else begin : g_norange
            assign addr_bad = 1'b0;
        end
    endgenerate

    assign run = (q.st != ST_IDLE);

    mdio_clk_gen #(.HALF_DIV(HALF_DIV)) i_clk_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .mdc    (mdc),
        .lo_end (lo_end),
        .hi_end (hi_end)
    );

    mdio_frame_fmt #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)) i_fmt (
        .is_write (req_write),
        .phy      (req_phy),
        .regad    (req_reg[REG_W-1:0]),
        .wdata    (req_wdata),
        .frame    (frame)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (addr_bad) begin
                        d.done = 1'b1;
                        if (!req_write) d.rdata = '1;
                    end else begin
                        d.st  = ST_PRE;
                        d.cnt = CNT_W'(PRE_BITS - 1);
                        d.wr  = req_write;
                        d.sh  = frame;
                        d.mo  = 1'b1;
                        d.oe  = 1'b1;
                    end
                end
            end
            ST_PRE: begin
                if (hi_end) begin
                    if (q.cnt == '0) begin
                        d.st  = ST_CMD;
                        d.cnt = q.wr ? CNT_W'(WR_BITS - 1) : CNT_W'(RD_CMD - 1);
                        d.mo  = q.sh[WR_BITS-1];
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            ST_CMD: begin
                if (hi_end) begin
                    if (q.cnt == '0) begin
                        d.oe  = 1'b0;
                        d.mo  = 1'b0;
                        d.st  = q.wr ? ST_TAIL : ST_RDIN;
                        d.cnt = q.wr ? CNT_W'(TAIL - 1) : CNT_W'(RD_IN - 1);
                    end else begin
                        d.sh  = q.sh << 1;
                        d.mo  = q.sh[WR_BITS-2];
                        d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            ST_RDIN: begin
                if (lo_end && q.cnt != '0)
                    d.din = {q.din[DATA_W-2:0], mdio_i};
                if (hi_end) begin
                    if (q.cnt == '0) begin
                        d.rdata = q.din;
                        d.done  = 1'b1;
                        d.st    = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (hi_end) begin
                    if (q.cnt == '0) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy    = run;
    assign done    = q.done;
    assign rd_data = q.rdata;
    assign mdio_o  = q.mo;
    assign mdio_oe = q.oe;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    // R1: the bus is quiet whenever no transaction runs
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R8: nothing moves during the high half of the clock
    a_r8_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R8: an output change lands only where the clock is low
    a_r8_change_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mdio_o) && $past(busy)) |-> !mdc);

    // R10: busy ends only with a completion pulse
    a_r10_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10: completion is never reported while still busy
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind mdio_master mdio_master_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [7:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe, mdio_i;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    mdio_master i_mdio_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY-side monitor and responder
    logic         clr_mon = 1'b0;
    int           rises = 0;
    int           ocnt = 0;
    int           rd_idx = 0;
    logic [127:0] osh = '0;
    logic [18:0]  rsp = '1;
    longint       cyc = 0;
    longint       last_rise = -1;
    longint       period_meas = 0;

    always @(posedge clk) cyc = cyc + 1;

    always @(posedge mdc or posedge clr_mon) begin
        if (clr_mon) begin
            rises = 0; ocnt = 0; rd_idx = 0; osh = '0; last_rise = -1;
        end else begin
            rises = rises + 1;
            if (mdio_oe) begin
                osh  = {osh[126:0], mdio_o};
                ocnt = ocnt + 1;
            end else begin
                rd_idx = rd_idx + 1;
            end
            if (last_rise >= 0) period_meas = cyc - last_rise;
            last_rise = cyc;
        end
    end

    assign mdio_i = (rd_idx < 19) ? rsp[5'(18 - rd_idx)] : 1'b1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic start_req(input bit wr, input logic [4:0] phy, input logic [7:0] rg,
                             input logic [15:0] wd);
        @(negedge clk);
        clr_mon   = 1'b1;
        req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
        req_valid = 1'b1;
        #1 clr_mon = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 5000) begin
            @(posedge clk); lat++;
            @(negedge clk);
        end
    endtask

    task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] val);
        int lat;
        rsp = {2'b10, val, 1'b1};
        start_req(1'b0, phy, {3'b000, rg}, 16'h0);
        check(busy == 1'b1, "R10 busy after accept", busy, 1);
        wait_done(lat);
        check(lat == 132 * HALF, "R11 read latency", lat, 132 * HALF);
        check(rd_data == val, "R5 read data", rd_data, val);
        check(ocnt == 47, "R4 driven bit count", ocnt, 47);
        check(osh[46:14] == {33{1'b1}}, "R3 preamble ones", osh[46:14], 64'h1FFFFFFFF);
        check(osh[13:0] == {4'b0110, phy, rg}, "R4 read command", osh[13:0], {4'b0110, phy, rg});
        check(rises == 66, "R5 mdc edge count", rises, 66);
        @(negedge clk);
        check(done == 1'b0, "R11 done single pulse", done, 0);
    endtask

    task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] val);
        int lat;
        start_req(1'b1, phy, {3'b000, rg}, val);
        wait_done(lat);
        check(lat == 134 * HALF, "R11 write latency", lat, 134 * HALF);
        check(ocnt == 65, "R6 driven bit count", ocnt, 65);
        check(osh[64:32] == {33{1'b1}}, "R3 preamble ones", osh[64:32], 64'h1FFFFFFFF);
        check(osh[31:0] == {4'b0101, phy, rg, 2'b10, val}, "R6 write frame",
              osh[31:0], {4'b0101, phy, rg, 2'b10, val});
        check(rises - ocnt == 2, "R7 released tail clocks", rises - ocnt, 2);
        @(negedge clk);
        check(done == 1'b0, "R11 done single pulse", done, 0);
    endtask

    task automatic t_reject(input bit wr, input logic [7:0] rg, input logic [15:0] exp_rd);
        int lat;
        start_req(wr, 5'd1, rg, 16'h5555);
        check(busy == 1'b0, "R9 no busy on reject", busy, 0);
        wait_done(lat);
        check(lat == 0, "R9 immediate done", lat, 0);
        check(rd_data == exp_rd, "R9 reject read data", rd_data, exp_rd);
        repeat (4 * HALF) @(negedge clk);
        check(rises == 0, "R9 no bus activity", rises, 0);
    endtask

    task automatic t_busy_ignore();
        int lat;
        rsp = {2'b10, 16'h6B2D, 1'b1};
        start_req(1'b0, 5'd9, 8'd3, 16'h0);
        repeat (100) @(negedge clk);
        req_write = 1'b1; req_phy = 5'd2; req_reg = 8'd4; req_wdata = 16'hDEAD;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(lat);
        check(rd_data == 16'h6B2D, "R10 running read unaffected", rd_data, 16'h6B2D);
        check(osh[13:0] == {4'b0110, 5'd9, 5'd3}, "R10 command of first request",
              osh[13:0], {4'b0110, 5'd9, 5'd3});
        check(busy == 1'b0, "R10 busy low at done", busy, 0);
        repeat (300) @(negedge clk);
        check(rises == 66 && busy == 1'b0, "R10 ignored request not queued", rises, 66);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !mdc && !mdio_oe, "R1 reset state",
              {busy, done, mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!mdc && !mdio_oe, "R1 idle bus", {mdc, mdio_oe}, 0);

        t_read(5'd5, 5'd2, 16'h1234);
        check(period_meas == 2 * HALF, "R2 mdc period", period_meas, 2 * HALF);
        t_read(5'd17, 5'd30, 16'hA5C3);
        t_read(5'd0, 5'd0, 16'h0000);
        t_read(5'd31, 5'd1, 16'hFFFF);
        t_write(5'd31, 5'd31, 16'hBEEF);
        t_write(5'd6, 5'd4, 16'h01E1);
        check(rd_data == 16'hFFFF, "R6 write keeps read data", rd_data, 16'hFFFF);
        t_reject(1'b1, 8'h20, 16'hFFFF);
        t_read(5'd3, 5'd7, 16'h0F0F);
        t_reject(1'b1, 8'hC1, 16'h0F0F);
        t_reject(1'b0, 8'h25, 16'hFFFF);
        t_busy_ignore();

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule